// File: doc/BRIEF.md
# UART Register Bank with Receive FIFO and Interrupts

This block is the software-visible face of a serial port. A host reaches it through a simple 32-bit register bus. A word's register index is its byte offset shifted right by two. Received bytes arrive on a valid/ready byte stream and wait in a 16-entry receive FIFO until software reads the data register. A write to the data register sends its low byte out on a one-cycle byte strobe. Software sees flag, line-control, control, divisor, FIFO-level, mask, raw-status, masked-status and clear registers, plus a fixed identification window at the top of the map. A single level interrupt output combines the masked status bits.

Bus responses come from a two-state access sequencer. `ACC_IDLE` is the resting state. A read strobe moves it to `ACC_RESP`, where `bus_rvalid` is high and `bus_rdata` holds the value captured at the strobe. Another read strobe keeps it in `ACC_RESP`, and any other cycle returns it to `ACC_IDLE`. Writes take effect at the clock edge that samples them and produce no response. The receive count drives the empty, full and interrupt flags through a trigger value. The trigger is 1 after reset and is set back to 1 by any write to line control or FIFO-level select.

Top module: `uart_regbank`

## Requirements
- R1: The register index is `bus_addr >> 2`. A read strobe returns its value on `bus_rdata` with `bus_rvalid` high in the following cycle. Unmapped indices (for example 2) read 0.
- R2: After reset the registers read as follows: flags (index 6) 0x90, control (index 12) 0x300, FIFO-level select (index 13) 0x12, and every other register 0. After reset `irq` is low and `rx_ready` is high.
- R3: A byte on the receive stream is accepted when `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the FIFO holds 16 bytes, and a byte offered then is dropped.
- R4: An accepted byte clears the receive-empty flag (flag bit 4). It sets the receive-full flag (flag bit 6) if line-control bit 4 is 0 or if the count reaches 16. Flag bit 7 stays 1.
- R5: An accepted byte sets the receive raw interrupt (raw-status index 15, bit 4) when the count is at least the trigger. The trigger is 1 after reset and after any write to index 11 or index 13.
- R6: A read of index 0 returns the oldest byte in bits 7:0, or 0 if the FIFO is empty, and removes it. The read clears receive-full, sets receive-empty when the count becomes 0, and clears the receive raw bit when the count equals trigger minus one.
- R7: A write to index 0 drives its low byte on `tx_data` with `tx_valid` high for exactly the next cycle, and sets raw-status bit 5.
- R8: Writing ones to index 17 clears the matching raw-status bits. Index 16 reads raw AND mask (mask at index 14). `irq` is high exactly when that AND is nonzero in bit 4 or bit 5.
- R9: A write to index 11 that changes bit 4 empties the receive FIFO and its count. A write to index 11 that keeps bit 4 unchanged leaves the FIFO intact.
- R10: Writes to the flag register are ignored. Index 1 reads 0, and writes to it have no effect.
- R11: Indices 8, 9, 10, 11, 12, 13, 14 and 18 read back the last 32-bit value written to them.
- R12: Indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that bus accesses are single-cycle strobes with word-aligned addresses and that `rx_valid` is driven by a source that honours `rx_ready` or accepts that its byte is dropped. They also assume that no line-control write that toggles the FIFO-enable bit arrives in the same cycle as a byte. The stimulus drives every bus access and every byte for exactly one cycle with idle cycles between them. It never combines a flushing line-control write with an incoming byte, and it offers a byte to a full FIFO only on purpose, to observe that the byte is dropped.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int IX_DATA  = 0;
    localparam int IX_RSR   = 1;
    localparam int IX_FLAG  = 6;
    localparam int IX_LPDIV = 8;
    localparam int IX_IBAUD = 9;
    localparam int IX_FBAUD = 10;
    localparam int IX_LINE  = 11;
    localparam int IX_CTRL  = 12;
    localparam int IX_LEVEL = 13;
    localparam int IX_MASK  = 14;
    localparam int IX_RAW   = 15;
    localparam int IX_MSKD  = 16;
    localparam int IX_CLR   = 17;
    localparam int IX_DMA   = 18;
    localparam int IX_ID_LO = 'h3F8;
    localparam int IX_ID_HI = 'h3FF;

    localparam int FL_RX_FULL  = 6;
    localparam int FL_RX_EMPTY = 4;
    localparam int IRQ_TX_BIT  = 5;
    localparam int IRQ_RX_BIT  = 4;
    localparam int LINE_FEN    = 4;

    localparam logic [7:0]  FLAG_RST  = 8'h90;
    localparam logic [31:0] CTRL_RST  = 32'h0000_0300;
    localparam logic [31:0] LEVEL_RST = 32'h0000_0012;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;
endpackage

// File: rtl/uart_rb_rxfifo.sv
module uart_rb_rxfifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop = pop && (count != '0);
    assign head   = (count == '0) ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    // flush wins over a push or pop in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rb_access.sv
module uart_rb_access
    import uart_rb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic capture,
    output logic rvalid
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (req && !we) state_d = ACC_RESP;
            ACC_RESP: state_d = (req && !we) ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        capture = req && !we;
        rvalid  = (state_q == ACC_RESP);
    end
endmodule

// File: rtl/uart_rb_idrom.sv
module uart_rb_idrom (
    input  logic [2:0] sel,
    output logic [7:0] id_byte
);
    always_comb begin
        unique case (sel)
            3'd0: id_byte = 8'h11;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [IDX_W-1:0] idx;
    logic             wr, rd, capture, dr_read, push, flush;
    logic [7:0]       head, id_byte;
    logic [CNT_W-1:0] rx_count, cnt_after_pop, cnt_next;

    logic [7:0]  flags_q, flags_d;
    logic [31:0] lpdiv_q, ibaud_q, fbaud_q, line_q, ctrl_q, level_q, mask_q, dma_q;
    logic [1:0]  raw_q, raw_d;          // [1] transmit, [0] receive
    logic [CNT_W-1:0] trig_q;
    logic [31:0] raw_word, rd_val, rdata_q;
    logic        tx_valid_q;
    logic [7:0]  tx_data_q;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr      = bus_req && bus_we;
    assign rd      = bus_req && !bus_we;
    assign dr_read = rd && (idx == IDX_W'(IX_DATA));
    assign flush   = wr && (idx == IDX_W'(IX_LINE)) && (line_q[LINE_FEN] != bus_wdata[LINE_FEN]);
    assign rx_ready = (rx_count != FULL_CNT) && !flush;
    assign push    = rx_valid && rx_ready;

    uart_rb_rxfifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (rx_data),
        .pop   (dr_read),
        .flush (flush),
        .head  (head),
        .count (rx_count)
    );

    uart_rb_access u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .capture (capture),
        .rvalid  (bus_rvalid)
    );

    uart_rb_idrom u_idrom (
        .sel     (idx[2:0]),
        .id_byte (id_byte)
    );

    assign cnt_after_pop = rx_count - CNT_W'(dr_read && (rx_count != '0));
    assign cnt_next      = cnt_after_pop + CNT_W'(push);

    // receive flags: pop effects first, arrival effects override
    always_comb begin
        flags_d = flags_q;
        if (dr_read) begin
            flags_d[FL_RX_FULL] = 1'b0;
            if (cnt_after_pop == '0) flags_d[FL_RX_EMPTY] = 1'b1;
        end
        if (push) begin
            flags_d[FL_RX_EMPTY] = 1'b0;
            if (!line_q[LINE_FEN] || (cnt_next == FULL_CNT)) flags_d[FL_RX_FULL] = 1'b1;
        end
    end

    // raw status: clears first, new events override
    always_comb begin
        raw_d = raw_q;
        if (dr_read && (cnt_after_pop == trig_q - 1'b1)) raw_d[0] = 1'b0;
        if (wr && (idx == IDX_W'(IX_CLR))) begin
            if (bus_wdata[IRQ_RX_BIT]) raw_d[0] = 1'b0;
            if (bus_wdata[IRQ_TX_BIT]) raw_d[1] = 1'b0;
        end
        if (push && (cnt_next >= trig_q)) raw_d[0] = 1'b1;
        if (wr && (idx == IDX_W'(IX_DATA))) raw_d[1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAG_RST;
            raw_q   <= '0;
            trig_q  <= CNT_W'(1);
            lpdiv_q <= '0;
            ibaud_q <= '0;
            fbaud_q <= '0;
            line_q  <= '0;
            ctrl_q  <= CTRL_RST;
            level_q <= LEVEL_RST;
            mask_q  <= '0;
            dma_q   <= '0;
        end else begin
            flags_q <= flags_d;
            raw_q   <= raw_d;
            if (wr) begin
                unique case (int'(idx))
                    IX_LPDIV: lpdiv_q <= bus_wdata;
                    IX_IBAUD: ibaud_q <= bus_wdata;
                    IX_FBAUD: fbaud_q <= bus_wdata;
                    IX_LINE:  begin line_q  <= bus_wdata; trig_q <= CNT_W'(1); end
                    IX_CTRL:  ctrl_q  <= bus_wdata;
                    IX_LEVEL: begin level_q <= bus_wdata; trig_q <= CNT_W'(1); end
                    IX_MASK:  mask_q  <= bus_wdata;
                    IX_DMA:   dma_q   <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    assign raw_word = {26'd0, raw_q[1], raw_q[0], 4'd0};

    always_comb begin
        rd_val = '0;
        if ((int'(idx) >= IX_ID_LO) && (int'(idx) <= IX_ID_HI)) begin
            rd_val = {24'd0, id_byte};
        end else begin
            unique case (int'(idx))
                IX_DATA:  rd_val = {24'd0, head};
                IX_FLAG:  rd_val = {24'd0, flags_q};
                IX_LPDIV: rd_val = lpdiv_q;
                IX_IBAUD: rd_val = ibaud_q;
                IX_FBAUD: rd_val = fbaud_q;
                IX_LINE:  rd_val = line_q;
                IX_CTRL:  rd_val = ctrl_q;
                IX_LEVEL: rd_val = level_q;
                IX_MASK:  rd_val = mask_q;
                IX_RAW:   rd_val = raw_word;
                IX_MSKD:  rd_val = raw_word & mask_q;
                IX_DMA:   rd_val = dma_q;
                default:  rd_val = '0;   // includes the receive-status index
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            if (capture) rdata_q <= rd_val;
            tx_valid_q <= wr && (idx == IDX_W'(IX_DATA));
            if (wr && (idx == IDX_W'(IX_DATA))) tx_data_q <= bus_wdata[7:0];
        end
    end

    assign bus_rdata = rdata_q;
    assign tx_valid  = tx_valid_q;
    assign tx_data   = tx_data_q;
    assign irq       = (raw_q[1] && mask_q[IRQ_TX_BIT]) || (raw_q[0] && mask_q[IRQ_RX_BIT]);
endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  rx_count
);
    logic data_idx;
    assign data_idx = (bus_addr[ADDR_W-1:2] == '0);

    assert_read_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && data_idx) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CNT_W'(DEPTH)) |-> !rx_ready);

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && data_idx && rx_count == '0) |=> (bus_rdata == 32'd0));

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((rx_valid && rx_ready) || (bus_req && bus_we)));
endmodule

bind uart_regbank uart_regbank_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .irq        (irq),
    .rx_count   (rx_count)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    always #5 clk = ~clk;

    uart_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int ix, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(ix << 2); bus_wdata = d;
        if (ix == 0) tx_exp_q.push_back(d[7:0]);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_reg(input int ix, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(ix << 2);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // monitor: read responses and transmit strobes
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (rd_exp_q.size() == 0) check("R1 unexpected rvalid", 32'd1, 32'd0);
            else check(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
        end
        if (rst_n && tx_valid) begin
            if (tx_exp_q.size() == 0) check("R7 unexpected tx", 32'd1, 32'd0);
            else check("R7 tx byte", {24'd0, tx_data}, {24'd0, tx_exp_q.pop_front()});
        end
    end

    task automatic finish_run();
        check("R1 pending reads", rd_exp_q.size(), 0);
        check("R7 pending tx", tx_exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] ids [8];
        ids = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 irq low", irq, 0);
        check("R2 rx_ready high", rx_ready, 1);
        rd_reg(6, 32'h90, "R2 flags reset");
        rd_reg(12, 32'h300, "R2 control reset");
        rd_reg(13, 32'h12, "R2 level reset");
        rd_reg(14, 32'h0, "R2 mask reset");
        rd_reg(15, 32'h0, "R2 raw reset");
        rd_reg(9, 32'h0, "R2 ibaud reset");

        // R11 storage
        wr_reg(9, 32'h0000_1234);
        wr_reg(10, 32'h2A);
        wr_reg(8, 32'h7);
        wr_reg(12, 32'h301);
        wr_reg(18, 32'h3);
        wr_reg(13, 32'h3F);
        rd_reg(9, 32'h1234, "R11 ibaud");
        rd_reg(10, 32'h2A, "R11 fbaud");
        rd_reg(8, 32'h7, "R11 lpdiv");
        rd_reg(12, 32'h301, "R11 control");
        rd_reg(18, 32'h3, "R11 dma");
        rd_reg(13, 32'h3F, "R11 level");

        // R1 unmapped, R10 ignored writes
        rd_reg(2, 32'h0, "R1 unmapped");
        wr_reg(6, 32'h0);
        rd_reg(6, 32'h90, "R10 flag write ignored");
        wr_reg(1, 32'hFF);
        rd_reg(1, 32'h0, "R10 rsr reads zero");

        // R12 id window
        for (int i = 0; i < 8; i++) rd_reg('h3F8 + i, {24'd0, ids[i]}, "R12 id byte");

        // R7 / R8 transmit and interrupt clear
        wr_reg(0, 32'h0000_0141);
        rd_reg(15, 32'h20, "R7 raw tx set");
        check("R8 irq masked off", irq, 0);
        wr_reg(14, 32'h20);
        check("R8 irq on", irq, 1);
        rd_reg(16, 32'h20, "R8 masked status");
        wr_reg(17, 32'h20);
        check("R8 irq cleared", irq, 0);
        rd_reg(15, 32'h0, "R8 raw cleared");

        // R4/R5/R6 FIFO disabled
        wr_reg(14, 32'h10);
        push_byte(8'h61);
        check("R5 irq rx", irq, 1);
        rd_reg(6, 32'hC0, "R4 flags full when fifo off");
        rd_reg(15, 32'h10, "R5 raw rx");
        rd_reg(0, 32'h61, "R6 data");
        rd_reg(6, 32'h90, "R6 flags after pop");
        check("R6 irq cleared by pop", irq, 0);
        rd_reg(0, 32'h0, "R6 empty read zero");

        // FIFO enabled, ordering
        wr_reg(11, 32'h10);
        rd_reg(11, 32'h10, "R11 line");
        push_byte(8'h31); push_byte(8'h32); push_byte(8'h33);
        rd_reg(6, 32'h80, "R4 no full with fifo on");
        rd_reg(0, 32'h31, "R6 order 1");
        rd_reg(15, 32'h10, "R6 rx raw stays above trigger");
        rd_reg(0, 32'h32, "R6 order 2");
        rd_reg(0, 32'h33, "R6 order 3");
        rd_reg(6, 32'h90, "R6 empty again");
        rd_reg(15, 32'h0, "R6 rx raw cleared");

        // R3 fill to 16
        for (int i = 0; i < 16; i++) push_byte(8'h40 + 8'(i));
        check("R3 ready low when full", rx_ready, 0);
        rd_reg(6, 32'hC0, "R4 full at 16");
        push_byte(8'hEE);
        for (int i = 0; i < 16; i++) rd_reg(0, 32'h40 + i, "R3 drain order");
        rd_reg(0, 32'h0, "R3 dropped byte absent");
        check("R3 ready high after drain", rx_ready, 1);

        // R9 toggle flush
        push_byte(8'h55); push_byte(8'h56);
        wr_reg(11, 32'h00);
        rd_reg(0, 32'h0, "R9 toggle empties fifo");
        push_byte(8'h77);
        wr_reg(11, 32'h00);
        rd_reg(0, 32'h77, "R9 same bit keeps fifo");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule